// File: doc/BRIEF.md
# Multiplexed-Address CAM Bus Master

This block carries out a single byte-wide read or write to a conditional-access module that sits on a narrow shared bus. The same eight data lines carry the address and the data. Control is through active-low select, read and write strobes, and the target answers with an active-low acknowledge.

A client pulses `req` with the direction, a 16-bit address, a write byte, a slot number and a choice of chip select. The block then sends the address in two phases, low byte first. Each phase is latched by its own strobe. Next it sets the data lines for the access, pulls one chip select low, and then pulls the read or write strobe low. It waits for the target's acknowledge. The acknowledge passes through a synchronizer and is sampled on a slow tick; if no acknowledge comes within a tick budget, the access times out. In every case the block ends with a one-cycle `rsp_done` pulse, all strobes high and the bus released.

A request for any slot other than 0 is refused at once: the block gives a done pulse with `rsp_badslot` set and does not touch the bus.

Top module: `cam_bus_master`

## Requirements
- R1: While reset is held and in the first idle cycle after it, the outputs are idle: `cs0_n`, `cs1_n`, `rd_n` and `wr_n` are 1; `addr_lo_stb`, `addr_hi_stb`, `bus_oe` and `rsp_done` are 0.
- R2: The address low byte `req_addr[7:0]` is driven on `bus_dout` with `bus_oe`=1 and `addr_lo_stb`=1 for exactly LATCH_CYC cycles. During that time the selects and the read/write strobes stay high. `bus_dout` does not change in the cycle where `addr_lo_stb` falls.
- R3: After the low phase ends, the high byte `req_addr[15:8]` is driven with `addr_hi_stb`=1 for exactly LATCH_CYC cycles, and then `addr_hi_stb` falls. The two latch strobes are never high at the same time.
- R4: In the cycle where the chip select first goes low, a write (`req_wr`=1) has `bus_oe`=1 with `req_wdata` on `bus_dout`, and a read (`req_wr`=0) has `bus_oe`=0. `bus_oe` is 0 whenever `rd_n` is low.
- R5: `req_cs1`=0 selects `cs0_n` and `req_cs1`=1 selects `cs1_n`. At most one select is ever low.
- R6: `wr_n` (for a write) or `rd_n` (for a read) goes low only after the chip select is already low. `rd_n` and `wr_n` are never low together.
- R7: `ack_n` passes through a two-flop synchronizer and is sampled once every TICK_CYC cycles. After `ack_n` falls, `rsp_done` follows within TICK_CYC+3 cycles, with `rsp_timeout`=0. For a read, `rsp_rdata` holds the `bus_din` value that the target drives.
- R8: If `ack_n` stays high, the read/write strobe stays low for exactly TICK_CYC*TIMEOUT_TICKS cycles. Then `rsp_done` and `rsp_timeout` are both 1 in the same cycle.
- R9: `rsp_done` lasts one cycle. In that cycle all selects and read/write strobes are high and both latch strobes are low.
- R10: A request whose `req_slot` is not 0 gives a one-cycle `rsp_done` with `rsp_badslot`=1 in the cycle after the request. No latch strobe, select or `bus_oe` is asserted.
- R11: A request made while an access is in progress is ignored: the address that goes out and the single done pulse belong to the first request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Start pulse, taken only when idle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_slot | input | SLOT_W | Slot number, only 0 is valid |
| req_addr | input | 2*DATA_W | Access address |
| req_wdata | input | DATA_W | Write byte |
| req_cs1 | input | 1 | 0 = use cs0_n, 1 = use cs1_n |
| rsp_rdata | output | DATA_W | Read byte, updated at completion of a read |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_timeout | output | 1 | Set with rsp_done when no acknowledge arrived |
| rsp_badslot | output | 1 | Set with rsp_done when the slot was refused |
| bus_dout | output | DATA_W | Value driven on the shared lines |
| bus_din | input | DATA_W | Value sampled from the shared lines |
| bus_oe | output | 1 | 1 = drive the shared lines |
| addr_lo_stb | output | 1 | Low address byte latch strobe |
| addr_hi_stb | output | 1 | High address byte latch strobe |
| cs0_n | output | 1 | Active-low select, first target |
| cs1_n | output | 1 | Active-low select, second target |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| ack_n | input | 1 | Active-low acknowledge from the target |

## Verification
The hardest situations to reach from the ports are the two edges of the acknowledge window. One is an acknowledge in the very first strobe cycle, which must still go through the synchronizer and wait for a tick. The other is a target that never answers, where the strobe-low time must equal the full tick budget to the cycle. A behavioural target in the bench answers after a chosen number of strobe-low cycles, or never. It records both address phases and the order of select and strobe, so that random accesses with delays from zero to well inside the budget cover the first edge, and directed silent-target runs cover the second. A second request issued in the middle of an access probes the busy case.

// File: rtl/cbm_pkg.sv
package cbm_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_LO_HOLD,
    ST_LO_DROP,
    ST_HI_HOLD,
    ST_HI_DROP,
    ST_DATA,
    ST_SELECT,
    ST_STROBE
  } cbm_state_e;

  function automatic logic [3:0] idle_ctrl();
    // order: cs0_n, cs1_n, rd_n, wr_n
    return 4'b1111;
  endfunction

endpackage

// File: rtl/cbm_sync.sv
module cbm_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= RST_VAL;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= RST_VAL;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cbm_timer.sv
module cbm_timer #(
  parameter int TICK_CYC      = 8,
  parameter int TIMEOUT_TICKS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick,
  output logic expired
);
  localparam int CW = $clog2(TICK_CYC + 1);
  localparam int TW = $clog2(TIMEOUT_TICKS + 1);

  logic [CW-1:0] cyc_cnt;
  logic [TW-1:0] tick_cnt;

  assign tick    = run && (cyc_cnt == CW'(TICK_CYC - 1));
  assign expired = tick && (tick_cnt == TW'(TIMEOUT_TICKS - 1));

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cyc_cnt  <= '0;
      tick_cnt <= '0;
    end else if (tick) begin
      cyc_cnt  <= '0;
      tick_cnt <= tick_cnt + 1'b1;
    end else begin
      cyc_cnt  <= cyc_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/cbm_seq.sv
module cbm_seq
  import cbm_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int SLOT_W     = 2,
  parameter int VALID_SLOT = 0,
  parameter int LATCH_CYC  = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req,
  input  logic                  req_wr,
  input  logic [SLOT_W-1:0]     req_slot,
  input  logic [2*DATA_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]     req_wdata,
  input  logic                  req_cs1,
  input  logic                  tick,
  input  logic                  expired,
  input  logic                  ack_sync_n,
  input  logic [DATA_W-1:0]     bus_din,
  output logic                  wait_run,
  output logic [DATA_W-1:0]     rsp_rdata,
  output logic                  rsp_done,
  output logic                  rsp_timeout,
  output logic                  rsp_badslot,
  output logic [DATA_W-1:0]     bus_dout,
  output logic                  bus_oe,
  output logic                  addr_lo_stb,
  output logic                  addr_hi_stb,
  output logic                  cs0_n,
  output logic                  cs1_n,
  output logic                  rd_n,
  output logic                  wr_n
);
  localparam int LW = $clog2(LATCH_CYC + 1);

  cbm_state_e          state;
  logic [LW-1:0]       lat_cnt;
  logic                op_wr;
  logic                op_cs1;
  logic [2*DATA_W-1:0] op_addr;
  logic [DATA_W-1:0]   op_wdata;
  logic                slot_ok;
  logic                lat_full;
  logic                ack_seen;

  assign slot_ok  = (req_slot == SLOT_W'(VALID_SLOT));
  assign lat_full = (lat_cnt == LW'(LATCH_CYC));
  assign ack_seen = tick && !ack_sync_n;
  assign wait_run = (state == ST_STROBE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      lat_cnt     <= '0;
      op_wr       <= 1'b0;
      op_cs1      <= 1'b0;
      op_addr     <= '0;
      op_wdata    <= '0;
      rsp_rdata   <= '0;
      rsp_done    <= 1'b0;
      rsp_timeout <= 1'b0;
      rsp_badslot <= 1'b0;
      bus_dout    <= '0;
      bus_oe      <= 1'b0;
      addr_lo_stb <= 1'b0;
      addr_hi_stb <= 1'b0;
      {cs0_n, cs1_n, rd_n, wr_n} <= idle_ctrl();
    end else begin
      rsp_done    <= 1'b0;
      rsp_timeout <= 1'b0;
      rsp_badslot <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req) begin
            if (!slot_ok) begin
              rsp_done    <= 1'b1;
              rsp_badslot <= 1'b1;
            end else begin
              op_wr       <= req_wr;
              op_cs1      <= req_cs1;
              op_addr     <= req_addr;
              op_wdata    <= req_wdata;
              bus_dout    <= req_addr[DATA_W-1:0];
              bus_oe      <= 1'b1;
              addr_lo_stb <= 1'b1;
              lat_cnt     <= LW'(1);
              state       <= ST_LO_HOLD;
            end
          end
        end
        ST_LO_HOLD: begin
          if (lat_full) begin
            addr_lo_stb <= 1'b0;
            state       <= ST_LO_DROP;
          end else begin
            lat_cnt <= lat_cnt + 1'b1;
          end
        end
        ST_LO_DROP: begin
          bus_dout    <= op_addr[2*DATA_W-1:DATA_W];
          addr_hi_stb <= 1'b1;
          lat_cnt     <= LW'(1);
          state       <= ST_HI_HOLD;
        end
        ST_HI_HOLD: begin
          if (lat_full) begin
            addr_hi_stb <= 1'b0;
            state       <= ST_HI_DROP;
          end else begin
            lat_cnt <= lat_cnt + 1'b1;
          end
        end
        ST_HI_DROP: begin
          if (op_wr) begin
            bus_dout <= op_wdata;
            bus_oe   <= 1'b1;
          end else begin
            bus_oe   <= 1'b0;
          end
          state <= ST_DATA;
        end
        ST_DATA: begin
          cs0_n <= op_cs1;
          cs1_n <= !op_cs1;
          state <= ST_SELECT;
        end
        ST_SELECT: begin
          if (op_wr) wr_n <= 1'b0;
          else       rd_n <= 1'b0;
          state <= ST_STROBE;
        end
        ST_STROBE: begin
          if (ack_seen || expired) begin
            if (ack_seen && !op_wr) rsp_rdata <= bus_din;
            rsp_done    <= 1'b1;
            rsp_timeout <= !ack_seen;
            bus_oe      <= 1'b0;
            {cs0_n, cs1_n, rd_n, wr_n} <= idle_ctrl();
            state       <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cam_bus_master.sv
module cam_bus_master #(
  parameter int DATA_W        = 8,
  parameter int SLOT_W        = 2,
  parameter int VALID_SLOT    = 0,
  parameter int LATCH_CYC     = 2,
  parameter int TICK_CYC      = 8,
  parameter int TIMEOUT_TICKS = 16,
  parameter int SYNC_STAGES   = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req,
  input  logic                req_wr,
  input  logic [SLOT_W-1:0]   req_slot,
  input  logic [2*DATA_W-1:0] req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic                req_cs1,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic                rsp_done,
  output logic                rsp_timeout,
  output logic                rsp_badslot,
  output logic [DATA_W-1:0]   bus_dout,
  input  logic [DATA_W-1:0]   bus_din,
  output logic                bus_oe,
  output logic                addr_lo_stb,
  output logic                addr_hi_stb,
  output logic                cs0_n,
  output logic                cs1_n,
  output logic                rd_n,
  output logic                wr_n,
  input  logic                ack_n
);
  logic ack_sync_n;
  logic tick;
  logic expired;
  logic wait_run;

  cbm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ack_sync (
    .clk (clk),
    .rst (rst),
    .d   (ack_n),
    .q   (ack_sync_n)
  );

  cbm_timer #(.TICK_CYC(TICK_CYC), .TIMEOUT_TICKS(TIMEOUT_TICKS)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .run     (wait_run),
    .tick    (tick),
    .expired (expired)
  );

  cbm_seq #(
    .DATA_W(DATA_W), .SLOT_W(SLOT_W),
    .VALID_SLOT(VALID_SLOT), .LATCH_CYC(LATCH_CYC)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .req         (req),
    .req_wr      (req_wr),
    .req_slot    (req_slot),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .req_cs1     (req_cs1),
    .tick        (tick),
    .expired     (expired),
    .ack_sync_n  (ack_sync_n),
    .bus_din     (bus_din),
    .wait_run    (wait_run),
    .rsp_rdata   (rsp_rdata),
    .rsp_done    (rsp_done),
    .rsp_timeout (rsp_timeout),
    .rsp_badslot (rsp_badslot),
    .bus_dout    (bus_dout),
    .bus_oe      (bus_oe),
    .addr_lo_stb (addr_lo_stb),
    .addr_hi_stb (addr_hi_stb),
    .cs0_n       (cs0_n),
    .cs1_n       (cs1_n),
    .rd_n        (rd_n),
    .wr_n        (wr_n)
  );
endmodule

// File: rtl/cbm_checker.sv
module cbm_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              rsp_done,
  input logic              rsp_timeout,
  input logic              rsp_badslot,
  input logic [DATA_W-1:0] bus_dout,
  input logic              bus_oe,
  input logic              addr_lo_stb,
  input logic              addr_hi_stb,
  input logic              cs0_n,
  input logic              cs1_n,
  input logic              rd_n,
  input logic              wr_n
);
  logic ctrl_idle;
  assign ctrl_idle = cs0_n && cs1_n && rd_n && wr_n;

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (ctrl_idle && !addr_lo_stb && !addr_hi_stb && !bus_oe && !rsp_done));

  assert_latch_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    (addr_lo_stb || addr_hi_stb) |-> (ctrl_idle && bus_oe));

  assert_lo_byte_held_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(addr_lo_stb) |-> $stable(bus_dout));

  assert_latch_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
    !(addr_lo_stb && addr_hi_stb));

  assert_read_released_R4: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> !bus_oe);

  assert_one_select_R5: assert property (@(posedge clk) disable iff (rst)
    $countones({cs0_n, cs1_n}) >= 1);

  assert_strobe_after_cs_R6: assert property (@(posedge clk) disable iff (rst)
    ($fell(rd_n) || $fell(wr_n)) |-> ($past(!cs0_n) || $past(!cs1_n)));

  assert_one_direction_R6: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n && !wr_n));

  assert_timeout_with_done_R8: assert property (@(posedge clk) disable iff (rst)
    rsp_timeout |-> rsp_done);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
    rsp_done |-> (ctrl_idle && !addr_lo_stb && !addr_hi_stb));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);

  assert_badslot_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    rsp_badslot |-> (rsp_done && !rsp_timeout && !bus_oe && ctrl_idle));
endmodule

bind cam_bus_master cbm_checker #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .rsp_done    (rsp_done),
  .rsp_timeout (rsp_timeout),
  .rsp_badslot (rsp_badslot),
  .bus_dout    (bus_dout),
  .bus_oe      (bus_oe),
  .addr_lo_stb (addr_lo_stb),
  .addr_hi_stb (addr_hi_stb),
  .cs0_n       (cs0_n),
  .cs1_n       (cs1_n),
  .rd_n        (rd_n),
  .wr_n        (wr_n)
);

// File: tb/cam_bus_master_tb.sv
module cam_bus_master_tb;
  localparam int DATA_W = 8;
  localparam int SLOT_W = 2;
  localparam int LATCH  = 2;
  localparam int TICK   = 8;
  localparam int NTICK  = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req = 1'b0;
  logic              req_wr = 1'b0;
  logic [SLOT_W-1:0] req_slot = '0;
  logic [15:0]       req_addr = '0;
  logic [7:0]        req_wdata = '0;
  logic              req_cs1 = 1'b0;
  logic [7:0]        rsp_rdata;
  logic              rsp_done, rsp_timeout, rsp_badslot;
  logic [7:0]        bus_dout;
  logic [7:0]        bus_din = '0;
  logic              bus_oe, addr_lo_stb, addr_hi_stb;
  logic              cs0_n, cs1_n, rd_n, wr_n;
  logic              ack_n = 1'b1;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  cam_bus_master #(
    .DATA_W(DATA_W), .SLOT_W(SLOT_W), .VALID_SLOT(0),
    .LATCH_CYC(LATCH), .TICK_CYC(TICK), .TIMEOUT_TICKS(NTICK), .SYNC_STAGES(2)
  ) u_dut (
    .clk(clk), .rst(rst), .req(req), .req_wr(req_wr), .req_slot(req_slot),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_cs1(req_cs1),
    .rsp_rdata(rsp_rdata), .rsp_done(rsp_done), .rsp_timeout(rsp_timeout),
    .rsp_badslot(rsp_badslot), .bus_dout(bus_dout), .bus_din(bus_din),
    .bus_oe(bus_oe), .addr_lo_stb(addr_lo_stb), .addr_hi_stb(addr_hi_stb),
    .cs0_n(cs0_n), .cs1_n(cs1_n), .rd_n(rd_n), .wr_n(wr_n), .ack_n(ack_n)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit exp_timeout(input int ackd);
    return ackd < 0;
  endfunction

  // one access against a behavioural target; ackd < 0 means the target stays silent
  task automatic run_txn(input int slot, input bit wr, input logic [15:0] addr,
                         input logic [7:0] wd, input bit sel, input int ackd,
                         input logic [7:0] rdv, input bit poke);
    int lo_cnt = 0, hi_cnt = 0, stb_cnt = 0, cyc = 0;
    int lo_val = -1, hi_val = -1;
    bit seen_cs = 0, done = 0, bad_touch = 0;
    req = 1'b1; req_wr = wr; req_slot = SLOT_W'(slot); req_addr = addr;
    req_wdata = wd; req_cs1 = sel;
    @(negedge clk);
    req = 1'b0; req_addr = ~addr; req_wdata = ~wd; req_slot = '0;
    if (slot != 0) begin
      check(rsp_done && rsp_badslot, "R10 refused slot done", int'(rsp_badslot), 1);
      for (int k = 0; k < 6; k++) begin
        if (addr_lo_stb || addr_hi_stb || bus_oe || !cs0_n || !cs1_n) bad_touch = 1;
        @(negedge clk);
        if (rsp_done) bad_touch = 1;
      end
      check(!bad_touch, "R10 refused slot quiet bus", int'(bad_touch), 0);
      return;
    end
    while (!done && cyc < 2000) begin
      if (poke && cyc == 2) begin
        req = 1'b1; req_wr = !wr; req_addr = addr ^ 16'h5AA5; req_slot = '0;
      end else req = 1'b0;
      if (addr_lo_stb) begin
        lo_cnt++; lo_val = int'(bus_dout);
        if (!(cs0_n && cs1_n && rd_n && wr_n)) bad_touch = 1;
      end
      if (addr_hi_stb) begin
        hi_cnt++; hi_val = int'(bus_dout);
        if (lo_cnt == 0 || addr_lo_stb) bad_touch = 1;
      end
      if ((!cs0_n || !cs1_n) && !seen_cs) begin
        seen_cs = 1;
        check(lo_val == int'(addr[7:0]), "R2 low address byte", lo_val, int'(addr[7:0]));
        check(lo_cnt == LATCH, "R2 low strobe width", lo_cnt, LATCH);
        check(hi_val == int'(addr[15:8]), "R3 high address byte", hi_val, int'(addr[15:8]));
        check(hi_cnt == LATCH && !bad_touch, "R3 high strobe width and order", hi_cnt, LATCH);
        check(sel ? (!cs1_n && cs0_n) : (!cs0_n && cs1_n), "R5 select choice",
              int'({cs1_n, cs0_n}), sel ? 1 : 2);
        check(rd_n && wr_n, "R6 strobe not before select", int'({rd_n, wr_n}), 3);
        if (wr) check(bus_oe && bus_dout == wd, "R4 write byte on bus", int'(bus_dout), int'(wd));
        else    check(!bus_oe, "R4 read releases bus", int'(bus_oe), 0);
      end
      if (!rd_n || !wr_n) begin
        if (stb_cnt == 0)
          check(seen_cs && (wr ? (!wr_n && rd_n) : (!rd_n && wr_n)), "R6 direction strobe",
                int'({rd_n, wr_n}), wr ? 2 : 1);
        stb_cnt++;
        if (ackd >= 0 && stb_cnt == ackd + 1) begin
          ack_n = 1'b0; bus_din = rdv;
        end
      end
      if (rsp_done) begin
        done = 1;
        check(rsp_timeout == exp_timeout(ackd), "R8 timeout flag", int'(rsp_timeout),
              int'(exp_timeout(ackd)));
        if (ackd < 0)
          check(stb_cnt == TICK * NTICK, "R8 silent target strobe length", stb_cnt, TICK * NTICK);
        else begin
          check(stb_cnt > ackd && stb_cnt <= ackd + TICK + 3, "R7 acknowledge latency",
                stb_cnt, ackd + 1);
          if (!wr) check(rsp_rdata == rdv, "R7 read byte", int'(rsp_rdata), int'(rdv));
        end
        check(cs0_n && cs1_n && rd_n && wr_n && !addr_lo_stb && !addr_hi_stb,
              "R9 strobes idle at done", int'({cs0_n, cs1_n, rd_n, wr_n}), 15);
      end else begin
        @(negedge clk);
        cyc++;
      end
    end
    req = 1'b0;
    if (!done) check(0, "R7 access never finished", cyc, 0);
    @(negedge clk);
    ack_n = 1'b1; bus_din = 8'($urandom);
    bad_touch = 0;
    for (int k = 0; k < 4; k++) begin
      if (rsp_done || addr_lo_stb) bad_touch = 1;
      @(negedge clk);
    end
    check(!bad_touch, poke ? "R11 busy request ignored" : "R9 single done pulse",
          int'(bad_touch), 0);
  endtask

  initial begin
    void'($urandom(32'h1C3A_0057));
    repeat (3) @(negedge clk);
    check(cs0_n && cs1_n && rd_n && wr_n && !addr_lo_stb && !addr_hi_stb && !bus_oe && !rsp_done,
          "R1 idle during reset", int'({cs0_n, cs1_n, rd_n, wr_n}), 15);
    rst = 1'b0;
    @(negedge clk);
    check(cs0_n && cs1_n && rd_n && wr_n && !bus_oe && !rsp_done, "R1 idle after reset",
          int'(bus_oe), 0);
    // directed corners
    run_txn(0, 1'b1, 16'hA55A, 8'h3C, 1'b0, 0,  8'h00, 1'b0);
    run_txn(0, 1'b0, 16'h1234, 8'h00, 1'b1, 0,  8'hC9, 1'b0);
    run_txn(0, 1'b0, 16'hFF00, 8'h00, 1'b0, -1, 8'h00, 1'b0);
    run_txn(0, 1'b1, 16'h00FF, 8'h81, 1'b1, -1, 8'h00, 1'b0);
    run_txn(1, 1'b1, 16'h4444, 8'h11, 1'b0, 3,  8'h00, 1'b0);
    run_txn(3, 1'b0, 16'h4444, 8'h11, 1'b1, 3,  8'h00, 1'b0);
    run_txn(0, 1'b0, 16'hBEEF, 8'h00, 1'b0, 10, 8'h5E, 1'b1);
    run_txn(0, 1'b1, 16'h0F0F, 8'h77, 1'b1, 30, 8'h00, 1'b1);
    run_txn(0, 1'b0, 16'h7E81, 8'h00, 1'b1, 100, 8'hA1, 1'b0);
    // random traffic
    for (int n = 0; n < 40; n++) begin
      int d = int'($urandom_range(0, 60));
      if ($urandom_range(0, 9) == 0) d = -1;
      run_txn(($urandom_range(0, 7) == 0) ? int'($urandom_range(1, 3)) : 0,
              1'($urandom), 16'($urandom), 8'($urandom), 1'($urandom), d,
              8'($urandom), ($urandom_range(0, 4) == 0));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule